// File: doc/BRIEF.md
# PCI Configuration Port Decoder

This block serves the classic two-register path into PCI configuration space over an eight-byte I/O window. The lower four bytes of the window hold a 32-bit configuration address register. The upper four bytes form a data window. Software programs the address register first: bus, device, function and dword register. It then reads or writes through the data window, and the block converts that access into a configuration request to one of a small set of device slots.

Each host access can be 1, 2 or 4 bytes wide at any byte offset of the window. A write to the address register merges into the register in place and leaves the bytes it does not cover unchanged. A read of the address register returns the bytes starting at the addressed offset. A data-window access goes to a device only when the address names a slot on bus 0, function 0, and that slot is marked present. Any other data-window access completes inside the block. A read of an absent target returns all ones across the access width. A write to an absent target is dropped.

A host access is accepted when `host_valid` and `host_ready` are both high at a clock edge. The block holds `host_ready` low until it has answered with a one-cycle `host_done` pulse. For a forwarded access, the device request stays asserted, with stable fields, until the slot answers with `dev_done`.

Top module: `cfgport_decoder`

## Requirements
- R1: After a synchronous active-low reset, the address register reads 0, `host_ready` is 1, and both `host_done` and `dev_valid` are 0.
- R2: A write to window offset k (0 to 3) with size code 0, 1 or 2 (1, 2 or 4 bytes) replaces only address bits 8k up to 8k+8·bytes−1. Bits above 31 are dropped. All other bits, including bit 31, keep their values.
- R3: A read of window offset k (0 to 3) returns the address register shifted right by 8k and masked to the access width.
- R4: An offset of 8 or more, or size code 3, completes with `host_unsup` = 1 and read data 0. It leaves the address register unchanged and issues no device request.
- R5: A data-window access (offset 4 to 7) to a valid target raises `dev_valid` with the following fields: `dev_slot` equal to address bits [15:11]; `dev_reg` equal to {address[7:2], 2'b00} + (offset − 4); `dev_write`, `dev_size` and `dev_wdata` taken from the host access. The request and its fields hold until `dev_done`.
- R6: For a forwarded read, `host_rdata` is the slot's `dev_rdata` masked to the access width. `host_done` pulses in the cycle after `dev_done` is sampled.
- R7: The target is valid only when all of these hold: bus field [23:16] is 0, function field [10:8] is 0, device field [15:11] is below the slot count, and that slot's `dev_present` bit is 1. No other data-window access produces a device request.
- R8: A data-window read of an invalid target returns 0xFF, 0xFFFF or 0xFFFFFFFF for sizes 1, 2 and 4, with `host_unsup` = 0.
- R9: A data-window write to an invalid target completes with `host_unsup` = 0 and issues no device request.
- R10: `host_done` is a single-cycle pulse during which `host_ready` is low. Address-register, unsupported and invalid-target accesses complete in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Block can accept an access |
| host_write | input | 1 | 1 = write, 0 = read |
| host_offset | input | 4 | Byte offset in the I/O window |
| host_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = unsupported |
| host_wdata | input | 32 | Write data, right-aligned |
| host_done | output | 1 | One-cycle completion pulse |
| host_unsup | output | 1 | Access rejected (valid with host_done) |
| host_rdata | output | 32 | Read data, right-aligned (valid with host_done) |
| dev_present | input | 5 | One bit per slot, 1 = device present |
| dev_valid | output | 1 | Configuration request to a slot |
| dev_write | output | 1 | Request is a write |
| dev_slot | output | 3 | Target slot index |
| dev_reg | output | 8 | Configuration byte register index |
| dev_size | output | 2 | Size code of the request |
| dev_wdata | output | 32 | Write data of the request |
| dev_done | input | 1 | Slot completes the request |
| dev_rdata | input | 32 | Slot read data, sampled with dev_done |

## Verification
The checker relies on a few properties of the inputs. `dev_present` stays stable while a device request is outstanding. `dev_done` is raised only while `dev_valid` is high. Host inputs change only while no access is in flight. The bench meets all three. It changes the presence mask only between accesses. Its slot model raises `dev_done` for exactly one cycle, a slot-dependent number of cycles after it sees `dev_valid`. Its driver presents an access only after it has seen `host_ready` and withdraws it right after the accepting edge.

// File: rtl/cfgport_pkg.sv
// Shared types and helpers for the configuration port decoder.
// Assumes a 32-bit address register in type-1 layout.
package cfgport_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_RESP = 2'd2
    } ctl_state_e;

    // Right-aligned mask covering the bytes of one access size.
    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
        case (acc_size_e'(sz))
            SZ_BYTE: width_mask = DATA_W'(32'h0000_00FF);
            SZ_HALF: width_mask = DATA_W'(32'h0000_FFFF);
            default: width_mask = {DATA_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/cfgport_addr_reg.sv
// Configuration address register with byte-granular merge on write and
// shifted, width-masked extraction on read.
// Assumes byte_ofs is 0..3 and that size has already been checked
// (a size code of 3 never reaches wr_en).
module cfgport_addr_reg
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        byte_ofs,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] rd_data
);

    logic [4:0]        bit_shift;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] lane_data;

    // Place the access lanes at their byte position; bytes above bit 31 fall off.
    always_comb begin
        bit_shift = {byte_ofs, 3'b000};
        lane_mask = width_mask(size) << bit_shift;
        lane_data = (wdata & width_mask(size)) << bit_shift;
    end

    // Keep the register, replacing only the covered lanes on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_en) begin
            addr_q <= (addr_q & ~lane_mask) | lane_data;
        end
    end

    // Bring the addressed bytes down to bit 0 and trim to the access width.
    always_comb begin
        rd_data = (addr_q >> bit_shift) & width_mask(size);
    end

endmodule

// File: rtl/cfgport_target_check.sv
// Decides whether the decoded bus/device/function names a present slot.
// Assumes a single bus (bus 0) and single-function devices.
module cfgport_target_check #(
    parameter int NUM_SLOTS = 5,
    parameter int SLOT_W    = 3
) (
    input  logic [7:0]           bus_num,
    input  logic [4:0]           dev_num,
    input  logic [2:0]           func_num,
    input  logic [NUM_SLOTS-1:0] present,
    output logic                 hit,
    output logic [SLOT_W-1:0]    slot
);

    logic [NUM_SLOTS-1:0] slot_sel;

    // One comparator per slot: a device number beyond the slots selects none.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_cmp
        assign slot_sel[i] = (dev_num == 5'(i));
    end

    // Valid only on bus 0, function 0, at a present slot.
    always_comb begin
        hit  = (bus_num == 8'd0) && (func_num == 3'd0) && (|(slot_sel & present));
        slot = dev_num[SLOT_W-1:0];
    end

endmodule

// File: rtl/cfgport_fwd_ctrl.sv
// Access sequencer: idle -> (forward to slot) -> respond -> idle.
// Assumes dev_done is only raised while a request is outstanding.
module cfgport_fwd_ctrl
    import cfgport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic to_dev,
    input  logic dev_done,
    output logic ready,
    output logic done,
    output logic dev_busy
);

    ctl_state_e state_q;

    // Advance the sequence on acceptance, on slot completion and after the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) state_q <= to_dev ? ST_FWD : ST_RESP;
                ST_FWD:  if (dev_done) state_q <= ST_RESP;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode the handshake outputs from the state.
    always_comb begin
        ready    = (state_q == ST_IDLE);
        done     = (state_q == ST_RESP);
        dev_busy = (state_q == ST_FWD);
    end

endmodule

// File: rtl/cfgport_decoder.sv
// Two-port configuration access decoder: address register at window
// offsets 0..3, data window at offsets 4..7. Data accesses go to a present
// slot or complete locally (all-ones read, dropped write).
// Assumes host inputs are held only for the accepting cycle.
module cfgport_decoder
    import cfgport_pkg::*;
#(
    parameter int NUM_SLOTS = 5,
    parameter int OFS_W     = 4,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_valid,
    output logic                 host_ready,
    input  logic                 host_write,
    input  logic [OFS_W-1:0]     host_offset,
    input  logic [1:0]           host_size,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic                 host_done,
    output logic                 host_unsup,
    output logic [DATA_W-1:0]    host_rdata,
    input  logic [NUM_SLOTS-1:0] dev_present,
    output logic                 dev_valid,
    output logic                 dev_write,
    output logic [SLOT_W-1:0]    dev_slot,
    output logic [7:0]           dev_reg,
    output logic [1:0]           dev_size,
    output logic [DATA_W-1:0]    dev_wdata,
    input  logic                 dev_done,
    input  logic [DATA_W-1:0]    dev_rdata
);

    localparam int WINDOW_BYTES = 8;
    localparam int DATA_PORT    = 4;

    logic              accept;
    logic              bad_acc;
    logic              is_addr_port;
    logic              tgt_hit;
    logic              to_dev;
    logic [SLOT_W-1:0] tgt_slot;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] addr_rd;
    logic [7:0]        reg_idx;

    logic              write_q;
    logic [1:0]        size_q;
    logic [SLOT_W-1:0] slot_q;
    logic [7:0]        reg_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] resp_q;
    logic              unsup_q;

    // Classify the incoming access.
    always_comb begin
        accept       = host_valid && host_ready;
        bad_acc      = (32'(host_offset) >= WINDOW_BYTES) || (acc_size_e'(host_size) == SZ_BAD);
        is_addr_port = (32'(host_offset) < DATA_PORT);
        to_dev       = !bad_acc && !is_addr_port && tgt_hit;
        reg_idx      = {addr_q[7:2], 2'b00} + {6'd0, host_offset[1:0]};
    end

    cfgport_addr_reg u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept && !bad_acc && is_addr_port && host_write),
        .byte_ofs (host_offset[1:0]),
        .size     (host_size),
        .wdata    (host_wdata),
        .addr_q   (addr_q),
        .rd_data  (addr_rd)
    );

    cfgport_target_check #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_tgt (
        .bus_num  (addr_q[23:16]),
        .dev_num  (addr_q[15:11]),
        .func_num (addr_q[10:8]),
        .present  (dev_present),
        .hit      (tgt_hit),
        .slot     (tgt_slot)
    );

    cfgport_fwd_ctrl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .to_dev   (to_dev),
        .dev_done (dev_done),
        .ready    (host_ready),
        .done     (host_done),
        .dev_busy (dev_valid)
    );

    // Capture the request fields that the slot sees while forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            size_q  <= 2'd0;
            slot_q  <= '0;
            reg_q   <= 8'd0;
            wdata_q <= '0;
        end else if (accept) begin
            write_q <= host_write;
            size_q  <= host_size;
            slot_q  <= tgt_slot;
            reg_q   <= reg_idx;
            wdata_q <= host_wdata;
        end
    end

    // Build the host response: local result at acceptance, slot data at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q  <= '0;
            unsup_q <= 1'b0;
        end else if (accept) begin
            unsup_q <= bad_acc;
            if (bad_acc || host_write || to_dev) begin
                resp_q <= '0;
            end else if (is_addr_port) begin
                resp_q <= addr_rd;
            end else begin
                resp_q <= width_mask(host_size);
            end
        end else if (dev_valid && dev_done) begin
            resp_q <= write_q ? '0 : (dev_rdata & width_mask(size_q));
        end
    end

    // Drive the slot request and host response from the captured state.
    always_comb begin
        dev_write  = write_q;
        dev_size   = size_q;
        dev_slot   = slot_q;
        dev_reg    = reg_q;
        dev_wdata  = wdata_q;
        host_rdata = resp_q;
        host_unsup = unsup_q;
    end

endmodule

// File: rtl/cfgport_decoder_checker.sv
// Protocol properties of the decoder's host and slot handshakes.
// Assumes dev_present is stable while a request is outstanding.
module cfgport_decoder_checker #(
    parameter int NUM_SLOTS = 5,
    parameter int SLOT_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_valid,
    input logic                 host_ready,
    input logic                 host_done,
    input logic                 dev_valid,
    input logic                 dev_done,
    input logic                 dev_write,
    input logic [SLOT_W-1:0]    dev_slot,
    input logic [7:0]           dev_reg,
    input logic [NUM_SLOTS-1:0] dev_present
);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid && !dev_done |=> dev_valid && $stable(dev_reg) && $stable(dev_slot) && $stable(dev_write));

    assert_req_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_valid) |-> $past(host_valid && host_ready));

    assert_present_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid |-> (int'(dev_slot) < NUM_SLOTS) && (((dev_present >> dev_slot) & NUM_SLOTS'(1)) != '0));

    assert_resp_after_dev_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid && dev_done |=> !dev_valid && host_done);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    assert_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> !host_ready);

endmodule

bind cfgport_decoder cfgport_decoder_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_valid  (host_valid),
    .host_ready  (host_ready),
    .host_done   (host_done),
    .dev_valid   (dev_valid),
    .dev_done    (dev_done),
    .dev_write   (dev_write),
    .dev_slot    (dev_slot),
    .dev_reg     (dev_reg),
    .dev_present (dev_present)
);

// File: tb/cfgport_decoder_tb_top.sv
// Scoreboard bench: the driver queues expected responses and slot requests;
// monitors pop and compare them as the decoder produces them.
module cfgport_decoder_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] rdata;
        bit          unsup;
        string       tag;
    } host_exp_t;

    typedef struct {
        logic [2:0]  slot;
        logic [7:0]  regi;
        bit          wr;
        logic [1:0]  sz;
        logic [31:0] wd;
        string       tag;
    } dev_exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic        host_write = 1'b0;
    logic [3:0]  host_offset = 4'd0;
    logic [1:0]  host_size = 2'd0;
    logic [31:0] host_wdata = 32'd0;
    logic        host_done;
    logic        host_unsup;
    logic [31:0] host_rdata;
    logic [4:0]  dev_present = 5'b01011;
    logic        dev_valid;
    logic        dev_write;
    logic [2:0]  dev_slot;
    logic [7:0]  dev_reg;
    logic [1:0]  dev_size;
    logic [31:0] dev_wdata;
    logic        dev_done = 1'b0;
    logic [31:0] dev_rdata = 32'd0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    host_exp_t host_q[$];
    dev_exp_t  dev_q[$];
    logic [31:0] model_addr = 32'd0;

    cfgport_decoder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_valid  (host_valid),
        .host_ready  (host_ready),
        .host_write  (host_write),
        .host_offset (host_offset),
        .host_size   (host_size),
        .host_wdata  (host_wdata),
        .host_done   (host_done),
        .host_unsup  (host_unsup),
        .host_rdata  (host_rdata),
        .dev_present (dev_present),
        .dev_valid   (dev_valid),
        .dev_write   (dev_write),
        .dev_slot    (dev_slot),
        .dev_reg     (dev_reg),
        .dev_size    (dev_size),
        .dev_wdata   (dev_wdata),
        .dev_done    (dev_done),
        .dev_rdata   (dev_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] szmask(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] slot_word(input logic [2:0] s, input logic [7:0] r);
        return {5'd0, s, r, 8'hC3, ~r};
    endfunction

    function automatic logic [31:0] mk_addr(input bit en, input logic [7:0] bus,
                                            input logic [4:0] dv, input logic [2:0] fn,
                                            input logic [7:0] r);
        return {en, 7'd0, bus, dv, fn, r[7:2], 2'b00};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one host access and wait for its completion.
    task automatic access(input bit wr, input logic [3:0] ofs, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] exp_rd,
                          input bit exp_unsup, input bit is_local, input string tag);
        int lat;
        host_q.push_back('{exp_rd, exp_unsup, tag});
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_offset = ofs; host_size = sz; host_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        host_valid = 1'b0;
        lat = 1;
        while (!host_done) begin
            @(negedge clk);
            lat++;
        end
        if (is_local) check(lat == 1, {tag, " R10 local latency"}, 32'(lat), 32'd1);
    endtask

    task automatic expect_dev(input logic [2:0] s, input logic [7:0] r, input bit wr,
                              input logic [1:0] sz, input logic [31:0] wd, input string tag);
        dev_q.push_back('{s, r, wr, sz, wd, tag});
    endtask

    // Host-side monitor: compare each completion against the queue head.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && host_done) begin
                if (host_q.size() == 0) begin
                    check(1'b0, "R10 unexpected host_done", 32'd1, 32'd0);
                end else begin
                    host_exp_t e;
                    e = host_q.pop_front();
                    check(host_rdata == e.rdata, {e.tag, " rdata"}, host_rdata, e.rdata);
                    check(host_unsup == e.unsup, {e.tag, " unsup"}, 32'(host_unsup), 32'(e.unsup));
                end
            end
        end
    end

    // Slot model: compare each request, answer after slot+1 cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && dev_valid) begin
                logic [2:0] s;
                logic [7:0] r;
                s = dev_slot;
                r = dev_reg;
                if (dev_q.size() == 0) begin
                    check(1'b0, "R7/R9 unexpected dev request", {24'd0, r}, 32'd0);
                end else begin
                    dev_exp_t d;
                    d = dev_q.pop_front();
                    check(dev_slot == d.slot, {d.tag, " slot"}, 32'(dev_slot), 32'(d.slot));
                    check(dev_reg == d.regi, {d.tag, " reg"}, 32'(dev_reg), 32'(d.regi));
                    check(dev_write == d.wr && dev_size == d.sz, {d.tag, " write/size"},
                          {29'd0, dev_write, dev_size}, {29'd0, d.wr, d.sz});
                    if (d.wr) check(dev_wdata == d.wd, {d.tag, " wdata"}, dev_wdata, d.wd);
                end
                repeat (int'(s)) @(negedge clk);
                dev_rdata = slot_word(s, r);
                dev_done  = 1'b1;
                @(negedge clk);
                dev_done  = 1'b0;
                dev_rdata = 32'd0;
            end
        end
    end

    // Watchdog: a hung run is a failure that still reaches the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(host_ready == 1'b1, "R1 host_ready", 32'(host_ready), 32'd1);
        check(host_done == 1'b0 && dev_valid == 1'b0, "R1 done/dev_valid",
              {30'd0, host_done, dev_valid}, 32'd0);
        access(1'b0, 4'd0, 2'd2, 32'd0, 32'd0, 1'b0, 1'b1, "R1 addr reads zero");

        // R2/R3: merges and extractions of the address register
        model_addr = 32'h8000_0810;
        access(1'b1, 4'd0, 2'd2, model_addr, 32'd0, 1'b0, 1'b1, "R2 word write");
        access(1'b0, 4'd0, 2'd2, 32'd0, model_addr, 1'b0, 1'b1, "R2 word readback");
        model_addr = 32'h805A_0810;
        access(1'b1, 4'd2, 2'd0, 32'hABCD_EF5A, 32'd0, 1'b0, 1'b1, "R2 byte write ofs2");
        access(1'b0, 4'd2, 2'd0, 32'd0, 32'h5A, 1'b0, 1'b1, "R3 byte read ofs2");
        access(1'b0, 4'd1, 2'd1, 32'd0, 32'h5A08, 1'b0, 1'b1, "R3 half read ofs1");
        access(1'b0, 4'd3, 2'd2, 32'd0, 32'h80, 1'b0, 1'b1, "R3 word read ofs3");
        model_addr = 32'h345A_0810;
        access(1'b1, 4'd3, 2'd1, 32'h0000_1234, 32'd0, 1'b0, 1'b1, "R2 half write ofs3 truncates");
        access(1'b0, 4'd0, 2'd2, 32'd0, model_addr, 1'b0, 1'b1, "R2 readback after truncation");

        // R4: unsupported offsets and size code
        access(1'b1, 4'd9, 2'd0, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b1, "R4 offset 9 write");
        access(1'b1, 4'd1, 2'd3, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b1, "R4 size code 3 write");
        access(1'b0, 4'd12, 2'd2, 32'd0, 32'd0, 1'b1, 1'b1, "R4 offset 12 read");
        access(1'b0, 4'd0, 2'd2, 32'd0, model_addr, 1'b0, 1'b1, "R4 addr unchanged");

        // R5/R6: forwarded accesses to slot 1
        access(1'b1, 4'd0, 2'd2, mk_addr(1'b1, 8'd0, 5'd1, 3'd0, 8'h10), 32'd0, 1'b0, 1'b1, "R2 set slot1");
        expect_dev(3'd1, 8'h10, 1'b0, 2'd2, 32'd0, "R5 read ofs4");
        access(1'b0, 4'd4, 2'd2, 32'd0, slot_word(3'd1, 8'h10), 1'b0, 1'b0, "R6 word read");
        expect_dev(3'd1, 8'h12, 1'b0, 2'd0, 32'd0, "R5 read ofs6");
        access(1'b0, 4'd6, 2'd0, 32'd0, slot_word(3'd1, 8'h12) & szmask(2'd0), 1'b0, 1'b0, "R6 byte read masked");
        expect_dev(3'd1, 8'h11, 1'b1, 2'd1, 32'h0000_BEEF, "R5 write ofs5");
        access(1'b1, 4'd5, 2'd1, 32'h0000_BEEF, 32'd0, 1'b0, 1'b0, "R5 write completes");

        // R8/R9: slot 2 is absent
        access(1'b1, 4'd0, 2'd2, mk_addr(1'b1, 8'd0, 5'd2, 3'd0, 8'h04), 32'd0, 1'b0, 1'b1, "R2 set slot2");
        access(1'b0, 4'd4, 2'd1, 32'd0, 32'hFFFF, 1'b0, 1'b1, "R8 absent half read");
        access(1'b0, 4'd7, 2'd0, 32'd0, 32'hFF, 1'b0, 1'b1, "R8 absent byte read");
        access(1'b1, 4'd4, 2'd2, 32'h1234_5678, 32'd0, 1'b0, 1'b1, "R9 absent write dropped");

        // R7: bus, function and slot-range screening
        access(1'b1, 4'd0, 2'd2, mk_addr(1'b1, 8'd1, 5'd0, 3'd0, 8'h00), 32'd0, 1'b0, 1'b1, "R2 set bus1");
        access(1'b0, 4'd4, 2'd0, 32'd0, 32'hFF, 1'b0, 1'b1, "R7 bus1 rejected");
        access(1'b1, 4'd0, 2'd2, mk_addr(1'b1, 8'd0, 5'd0, 3'd2, 8'h00), 32'd0, 1'b0, 1'b1, "R2 set fn2");
        access(1'b0, 4'd4, 2'd2, 32'd0, 32'hFFFF_FFFF, 1'b0, 1'b1, "R7 fn2 rejected");
        access(1'b1, 4'd0, 2'd2, mk_addr(1'b1, 8'd0, 5'd6, 3'd0, 8'h00), 32'd0, 1'b0, 1'b1, "R2 set dev6");
        access(1'b0, 4'd4, 2'd1, 32'd0, 32'hFFFF, 1'b0, 1'b1, "R7 dev6 out of range");
        access(1'b1, 4'd0, 2'd2, mk_addr(1'b1, 8'd0, 5'd0, 3'd0, 8'h08), 32'd0, 1'b0, 1'b1, "R2 set slot0");
        expect_dev(3'd0, 8'h08, 1'b0, 2'd2, 32'd0, "R7 slot0 forwarded");
        access(1'b0, 4'd4, 2'd2, 32'd0, slot_word(3'd0, 8'h08), 1'b0, 1'b0, "R6 slot0 read");

        // R5: top register index with offset 7 on slot 3
        access(1'b1, 4'd0, 2'd2, mk_addr(1'b0, 8'd0, 5'd3, 3'd0, 8'hFC), 32'd0, 1'b0, 1'b1, "R2 set slot3");
        expect_dev(3'd3, 8'hFF, 1'b0, 2'd0, 32'd0, "R5 reg FC+3");
        access(1'b0, 4'd7, 2'd0, 32'd0, slot_word(3'd3, 8'hFF) & 32'hFF, 1'b0, 1'b0, "R6 slot3 byte read");

        repeat (8) @(negedge clk);
        check(host_q.size() == 0, "R10 all responses seen", 32'(host_q.size()), 32'd0);
        check(dev_q.size() == 0, "R5 all slot requests seen", 32'(dev_q.size()), 32'd0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule